// File: doc/BRIEF.md
# SDLC Receive Address Filter

This block sits in the receive path of a bit-oriented link controller, after flag detection and zero-bit deletion. It watches a byte stream together with plain start-of-frame, end-of-frame and abort strobes. It decides on the first byte of each frame whether that frame belongs to this station, and then either forwards every byte of the frame, address byte included, or discards the whole frame. A single output register feeds the receive FIFO.

Filtering is active only when both `sdlc_mode` and `search_en` are high. In that case a frame is accepted when its first byte equals `station_addr`. When `nibble_only` is high, only the upper four bits of the address are compared, but the address field still occupies a whole byte. A received address whose compared bits are all ones is a broadcast and is always accepted. When filtering is inactive, every byte passes through unchanged.

Both byte interfaces use valid/ready. A byte moves when valid and ready are high on the same rising edge. `in_ready` is high whenever the output register is empty or is being drained in that cycle. A byte that is discarded is still consumed by the handshake, so the upstream stage never stalls on a rejected frame. While `out_valid` is high and `out_ready` is low, the output byte stays unchanged.

Top module: `sdlc_addr_filter`

## Requirements
- R1: With filtering active and `nibble_only`=0, a frame whose first byte equals `station_addr` in all 8 bits is accepted. `frame_accepted` goes high on the edge that consumes that byte. The address byte and every following byte of the frame appear on the output in order, each one cycle after its handshake.
- R2: With filtering active and `nibble_only`=1, only bits [7:4] of the first byte are compared with bits [7:4] of `station_addr`. Bits [3:0] are ignored. The whole 8-bit address byte is forwarded as data when the frame is accepted.
- R3: With filtering active, a frame whose address does not match produces no output byte at all, not even the address byte, and `frame_accepted` stays 0.
- R4: With `sdlc_mode`=0, every consumed byte is forwarded, whether it is inside or outside a frame and whatever its address.
- R5: With `sdlc_mode`=1 and `search_en`=0, every frame is accepted. `frame_accepted` rises after its first byte and all of its bytes are forwarded.
- R6: A first byte whose compared bits are all ones is accepted whatever `station_addr` holds. This means 8'hFF when `nibble_only`=0, and an upper nibble of 4'hF when `nibble_only`=1.
- R7: Both `abort` and `eof` clear `frame_accepted` on the next edge. Each frame is evaluated afresh. When strobes coincide, `abort` wins over `sof`, and `sof` wins over `eof`, so a shared closing/opening flag starts a new evaluation.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` is held. No forwarded byte is lost or duplicated under back-pressure.
- R9: After reset, `out_valid`=0, `frame_accepted`=0 and `in_ready`=1.
- R10: With filtering active, bytes consumed outside any frame are discarded. This covers bytes after `eof` or `abort` and before the next `sof`, and bytes of a frame already rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Filter can consume a byte |
| in_data | input | 8 | Received byte |
| sof | input | 1 | Opening flag seen (one-cycle strobe) |
| eof | input | 1 | Closing flag seen (one-cycle strobe) |
| abort | input | 1 | Abort pattern seen (one-cycle strobe) |
| sdlc_mode | input | 1 | Receiver is in bit-oriented framing mode |
| search_en | input | 1 | Address search enable |
| nibble_only | input | 1 | Compare only the upper four address bits |
| station_addr | input | 8 | Programmed station address |
| out_valid | output | 1 | Forwarded byte valid |
| out_ready | input | 1 | Receive FIFO can take a byte |
| out_data | output | 8 | Forwarded byte |
| frame_accepted | output | 1 | Current frame passed address filtering |

## Verification
The assertions assume that the framing strobes `sof`, `eof` and `abort` never fall on a cycle in which a byte is consumed, because the framer reports flags between characters. The bench drives every strobe on an idle cycle with `in_valid` low, and it keeps the mode and address inputs constant across each frame. Under that assumption, the properties check three things: rejected frames stay silent, strobes clear the acceptance state, and output holding under a stalled FIFO works as specified. A behavioural model in the bench predicts every forwarded byte and the acceptance flag on every cycle, with and without random back-pressure.

// File: rtl/sdlc_afilt_pkg.sv
package sdlc_afilt_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,   // outside any frame
    FR_ADDR = 2'd1,   // opening flag seen, waiting for address byte
    FR_PASS = 2'd2,   // frame accepted
    FR_DROP = 2'd3    // frame rejected
  } fr_state_t;

endpackage

// File: rtl/sdlc_afilt_match.sv
module sdlc_afilt_match #(
  parameter int ADDR_W = 8,
  parameter int HI_W   = 4
) (
  input  logic [ADDR_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] station,
  input  logic              hi_only,
  output logic              hit
);

  localparam int LO_W = ADDR_W - HI_W;

  logic [ADDR_W-1:0] cmp_mask;
  logic [ADDR_W-1:0] diff;
  logic              addr_eq;
  logic              bcast;

  generate
    if (LO_W > 0) begin : g_split
      localparam logic [ADDR_W-1:0] HI_MASK = {{HI_W{1'b1}}, {LO_W{1'b0}}};
      always_comb cmp_mask = hi_only ? HI_MASK : {ADDR_W{1'b1}};
    end else begin : g_whole
      always_comb cmp_mask = {ADDR_W{1'b1}};
    end
  endgenerate

  always_comb begin
    diff    = (rx_byte ^ station) & cmp_mask;
    addr_eq = (diff == '0);
    bcast   = ((rx_byte & cmp_mask) == cmp_mask);
    hit     = addr_eq | bcast;
  end

endmodule

// File: rtl/sdlc_afilt_fsm.sv
module sdlc_afilt_fsm
  import sdlc_afilt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      rx_hit,
  input  logic      filt_on,
  input  logic      sof,
  input  logic      eof,
  input  logic      abort,
  output logic      pass_byte,
  output fr_state_t state,
  output logic      accepted
);

  fr_state_t nxt;

  always_comb begin
    unique case (state)
      FR_IDLE: pass_byte = !filt_on;
      FR_ADDR: pass_byte = !filt_on || rx_hit;
      FR_PASS: pass_byte = 1'b1;
      FR_DROP: pass_byte = !filt_on;
      default: pass_byte = 1'b0;
    endcase
  end

  always_comb begin
    nxt = state;
    if (abort)                       nxt = FR_IDLE;
    else if (sof)                    nxt = FR_ADDR;
    else if (eof)                    nxt = FR_IDLE;
    else if (take && state == FR_ADDR)
      nxt = pass_byte ? FR_PASS : FR_DROP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= FR_IDLE;
    else        state <= nxt;
  end

  assign accepted = (state == FR_PASS);

  AST_SOF_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !abort) |=> (state == FR_ADDR)); // R7

  AST_DECIDE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FR_ADDR && take && !sof && !eof && !abort) |=>
      (state == FR_PASS || state == FR_DROP)); // R1

endmodule

// File: rtl/sdlc_afilt_ostage.sv
module sdlc_afilt_ostage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pass,
  output logic              take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign load     = take && pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid)); // R8

endmodule

// File: rtl/sdlc_addr_filter.sv
module sdlc_addr_filter
  import sdlc_afilt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              sof,
  input  logic              eof,
  input  logic              abort,
  input  logic              sdlc_mode,
  input  logic              search_en,
  input  logic              nibble_only,
  input  logic [DATA_W-1:0] station_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              frame_accepted
);

  logic      filt_on;
  logic      rx_hit;
  logic      pass_byte;
  logic      take;
  fr_state_t fr_state;

  assign filt_on = sdlc_mode && search_en;

  sdlc_afilt_match #(.ADDR_W(DATA_W), .HI_W(HI_W)) u_match (
    .rx_byte (in_data),
    .station (station_addr),
    .hi_only (nibble_only),
    .hit     (rx_hit)
  );

  sdlc_afilt_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .rx_hit    (rx_hit),
    .filt_on   (filt_on),
    .sof       (sof),
    .eof       (eof),
    .abort     (abort),
    .pass_byte (pass_byte),
    .state     (fr_state),
    .accepted  (frame_accepted)
  );

  sdlc_afilt_ostage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .pass      (pass_byte),
    .take      (take),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  AST_MARK_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof || eof || abort) |-> !(in_valid && in_ready)); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !frame_accepted); // R7

  AST_EOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !frame_accepted); // R7

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && fr_state == FR_DROP && in_valid && in_ready) |=> !out_valid); // R3

  AST_MODE_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdlc_mode && in_valid && in_ready) |=>
      (out_valid && out_data == $past(in_data))); // R4

  AST_ACCEPT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_accepted) |-> $past(in_valid && in_ready)); // R1

endmodule

// File: tb/sdlc_addr_filter_test.sv
module sdlc_addr_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       sof = 1'b0, eof = 1'b0, abort = 1'b0;
  logic       sdlc_mode = 1'b1, search_en = 1'b1, nibble_only = 1'b0;
  logic [7:0] station_addr = 8'h5A;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       frame_accepted;

  always #4 clk = ~clk;  // 125 MHz

  sdlc_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sof(sof), .eof(eof), .abort(abort),
    .sdlc_mode(sdlc_mode), .search_en(search_en), .nibble_only(nibble_only),
    .station_addr(station_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .frame_accepted(frame_accepted)
  );

  int total = 0, bad = 0, n_out = 0, cycles = 0;
  bit done = 0;
  bit stall = 0;
  string tag = "R9";
  logic [7:0] expq[$];
  int mst = 0;  // 0 idle, 1 addr, 2 accepted, 3 rejected

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // reference model, updated on each edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit filt, hit, p;
      logic [7:0] e;
      cycles++;
      if (out_valid && out_ready) begin
        n_out++;
        if (expq.size() == 0) chk(0, {tag, " unexpected byte"}, out_data, 0);
        else begin
          e = expq.pop_front();
          chk(out_data == e, {tag, " data"}, out_data, e);
        end
      end
      if (in_valid && in_ready) begin
        filt = sdlc_mode && search_en;
        hit = nibble_only ? (in_data[7:4] == station_addr[7:4] || in_data[7:4] == 4'hF)
                          : (in_data == station_addr || in_data == 8'hFF);
        case (mst)
          0: p = !filt;
          1: begin p = !filt || hit; mst = p ? 2 : 3; end
          2: p = 1;
          default: p = !filt;
        endcase
        if (p) expq.push_back(in_data);
      end
      if (abort) mst = 0;
      else if (sof) mst = 1;
      else if (eof) mst = 0;
      out_ready <= stall ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(frame_accepted == (mst == 2), {tag, " frame_accepted"}, frame_accepted, mst == 2);
      chk(in_ready == (!out_valid || out_ready), "R8 in_ready", in_ready, !out_valid || out_ready);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    in_data = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic mark(input bit s, input bit e, input bit a);
    sof = s; eof = e; abort = a;
    @(negedge clk);
    sof = 0; eof = 0; abort = 0;
  endtask

  task automatic frame(input logic [7:0] addr, input int len);
    mark(1, 0, 0);
    send(addr);
    for (int i = 0; i < len; i++) send(8'(addr + 8'(i) * 8'h13 + 8'h07));
    mark(0, 1, 0);
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  task automatic frame_cnt(input logic [7:0] addr, input int len, input int exp, input string t);
    int base;
    base = n_out;
    frame(addr, len);
    drain();
    chk(n_out - base == exp, {t, " byte count"}, n_out - base, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(out_valid == 0, "R9 out_valid", out_valid, 0);
    chk(frame_accepted == 0, "R9 frame_accepted", frame_accepted, 0);
    chk(in_ready == 1, "R9 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1"; frame_cnt(8'h5A, 3, 4, "R1");
    tag = "R3"; frame_cnt(8'h5B, 3, 0, "R3");
    tag = "R3"; frame_cnt(8'h4A, 2, 0, "R3");

    tag = "R2"; nibble_only = 1;
    frame_cnt(8'h53, 3, 4, "R2");
    frame_cnt(8'h6A, 3, 0, "R2");

    tag = "R6"; station_addr = 8'h12;
    frame_cnt(8'hF0, 2, 3, "R6");
    nibble_only = 0;
    frame_cnt(8'hFF, 2, 3, "R6");
    frame_cnt(8'hF2, 2, 0, "R6");

    // R10: bytes outside a frame are dropped
    tag = "R10";
    begin
      int base; base = n_out;
      send(8'h12); send(8'h34);
      drain();
      chk(n_out == base, "R10 out-of-frame count", n_out - base, 0);
    end

    // R4: non-SDLC mode passes everything
    tag = "R4"; sdlc_mode = 0;
    begin
      int base; base = n_out;
      send(8'h99);
      drain();
      chk(n_out - base == 1, "R4 loose byte", n_out - base, 1);
    end
    frame_cnt(8'h77, 2, 3, "R4");
    sdlc_mode = 1;

    // R5: search disabled accepts any frame
    tag = "R5"; search_en = 0;
    mark(1, 0, 0); send(8'h66);
    @(negedge clk);
    chk(frame_accepted == 1, "R5 accepted", frame_accepted, 1);
    send(8'h01); mark(0, 1, 0); drain();
    search_en = 1;

    // R7: abort ends accepted frame, later bytes dropped
    tag = "R7";
    mark(1, 0, 0); send(8'h12); send(8'h21);
    chk(frame_accepted == 1, "R7 accepted before abort", frame_accepted, 1);
    mark(0, 0, 1);
    chk(frame_accepted == 0, "R7 cleared by abort", frame_accepted, 0);
    begin
      int base; drain(); base = n_out;
      send(8'h12); drain();
      chk(n_out == base, "R7 after abort dropped", n_out - base, 0);
    end
    // shared flag: eof and sof together start a new evaluation
    mark(1, 0, 0); send(8'h12); mark(1, 1, 0);
    chk(frame_accepted == 0, "R7 sof over eof", frame_accepted, 0);
    send(8'h30); // mismatching address for new frame
    begin
      int base; drain(); base = n_out;
      send(8'h12); drain();
      chk(n_out == base, "R7 new frame rejected", n_out - base, 0);
    end
    // abort wins over sof
    mark(1, 0, 1);
    begin
      int base; base = n_out;
      send(8'h12); drain();
      chk(n_out == base, "R7 abort over sof", n_out - base, 0);
      chk(frame_accepted == 0, "R7 idle after abort+sof", frame_accepted, 0);
    end
    mark(0, 1, 0);

    // R8: random back-pressure, mixed frames
    tag = "R8"; stall = 1;
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      nibble_only = k[2];
      a = (k % 3 == 0) ? 8'h13 : 8'(k * 37);
      frame(a, k % 6);
    end
    drain(); stall = 0; drain();
    chk(expq.size() == 0, "R8 queue empty", expq.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule